// File: doc/BRIEF.md
# Multiplexed DRAM Control Sequencer

This block sits between the bus of an 8-bit processor and an array of row/column multiplexed dynamic RAM. It watches the processor's active-low memory request, read, write and refresh strobes and the 16-bit address. From these it produces the row strobe, the column strobe, the write enable, the row/column select for an external address multiplexer, and the multiplexed address that goes to the DRAM pins.

A read or write becomes a full row-then-column cycle. The row strobe opens the row. One clock later the multiplexer moves to the column half. One clock after that the column strobe falls. On a write the write enable falls before the column strobe, so the DRAM sees an early-write cycle. When memory request and refresh are low together, the block runs a row-only refresh. It drives the low seven address bits as the row and never asserts the column strobe.

As an option, the block watches address bit 6 across refresh cycles. It toggles an internal bit each time bit 6 falls and drives that bit as refresh row bit 7. This lets a seven-bit processor refresh counter cover 256 rows. The address split between row and column is set by a parameter: the 16K split (the default) or the wider 64K split. The `rst_n` input is asserted asynchronously and released synchronously inside the block.

Top module: `dram_seq_top`

## Requirements
- R1: While reset is held, and after it is released with no request, `ras_n`, `cas_n` and `we_n` are high and `mux_sel` is 0.
- R2: A read (`mreq_n` and `rd_n` low at a clock edge while idle) drives `ras_n` low after that edge, with `ma` = {0, addr[13:7]}. After the next edge `mux_sel` is 1 and `ma` = {0, addr[6:0]}. After the edge following that, `cas_n` is low. Both strobes then stay low while `mreq_n` stays low.
- R3: A write (`wr_n` low instead of `rd_n`) follows the same timing, with `we_n` low from the cycle in which `mux_sel` goes to 1, one cycle before `cas_n` falls. On a read, `we_n` stays high throughout.
- R4: `mreq_n` low with `rd_n`, `wr_n` and `rfsh_n` all high starts no cycle: `ras_n`, `cas_n` and `we_n` stay high and `mux_sel` stays 0.
- R5: `mreq_n` and `rfsh_n` low at an edge while idle drives `ras_n` low after that edge, with `ma[6:0]` = addr[6:0]. `cas_n` and `we_n` stay high and `mux_sel` stays 0 for the whole refresh. Address bits 7 and above do not reach `ma[6:0]`.
- R6: In refresh, `ma[7]` is an internal bit that is 0 after reset. It inverts at the start of each refresh whose addr[6] is 0 when the previous refresh had addr[6] = 1. With a 7-bit counter on addr[6:0], 256 consecutive refreshes therefore reach all 256 rows.
- R7: The clock edge that samples `mreq_n` high returns the block to idle. After that edge `ras_n`, `cas_n` and `we_n` are high and `mux_sel` is 0, including when the access is cut short before the column strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 16 | Processor address bus |
| mreq_n | input | 1 | Memory request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rfsh_n | input | 1 | Refresh strobe, active low |
| ras_n | output | 1 | DRAM row strobe, active low |
| cas_n | output | 1 | DRAM column strobe, active low |
| we_n | output | 1 | DRAM write enable, active low |
| mux_sel | output | 1 | Address multiplexer select: 0 row, 1 column |
| ma | output | 8 | Multiplexed DRAM address |

## Verification
The hardest case to reach is the eighth refresh row bit. It changes only when a falling edge of address bit 6 is seen across two separate refresh cycles. Its effect shows only after more than a hundred refreshes have walked a counter past its wrap. The stimulus runs a refresh counter on addr[6:0] for 300 cycles, with changing junk in the upper address bits. A reference toggle model in the bench predicts `ma[7]` for every refresh, and a row bitmap confirms that all 256 rows were reached.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  // Sequencer phase. The encoding is free; outputs are decoded by name.
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ROW  = 3'd1,
    PH_SWAP = 3'd2,
    PH_COL  = 3'd3,
    PH_REF  = 3'd4
  } seq_phase_t;

  // Width of one row or column half of the address for a chosen split.
  function automatic int half_width(input bit wide_split);
    return wide_split ? 8 : 7;
  endfunction

endpackage

// File: rtl/dram_rst_sync.sv
module dram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mreq_n,
  input  logic rd_n,
  input  logic wr_n,
  input  logic rfsh_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic col_sel,
  output logic in_ref,
  output logic ref_start
);

  seq_phase_t phase_q;
  seq_phase_t phase_d;
  logic       is_wr_q;
  logic       is_wr_d;
  logic       is_wr_en;
  logic       req_act;
  logic       xfer_req;

  assign req_act  = !mreq_n;
  assign xfer_req = !rd_n || !wr_n;

  // Next phase: refresh wins over a transfer; a released request always
  // returns to idle from any phase.
  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_act && !rfsh_n) begin
          phase_d = PH_REF;
        end else if (req_act && xfer_req) begin
          phase_d = PH_ROW;
        end
      end
      PH_ROW:  phase_d = req_act ? PH_SWAP : PH_IDLE;
      PH_SWAP: phase_d = req_act ? PH_COL  : PH_IDLE;
      PH_COL:  phase_d = req_act ? PH_COL  : PH_IDLE;
      PH_REF:  phase_d = req_act ? PH_REF  : PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  // Transfer direction is captured once, as the row strobe opens.
  assign is_wr_en = (phase_q == PH_IDLE) && (phase_d == PH_ROW);
  assign is_wr_d  = !wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_wr_q <= 1'b0;
    end else if (is_wr_en) begin
      is_wr_q <= is_wr_d;
    end
  end

  // Strobes decoded from the phase register only.
  assign ras_n     = (phase_q == PH_IDLE);
  assign col_sel   = (phase_q == PH_SWAP) || (phase_q == PH_COL);
  assign cas_n     = (phase_q != PH_COL);
  assign we_n      = !(is_wr_q && col_sel);
  assign in_ref    = (phase_q == PH_REF);
  assign ref_start = (phase_q == PH_IDLE) && (phase_d == PH_REF);

endmodule

// File: rtl/dram_refresh_ext.sv
module dram_refresh_ext #(
  parameter bit ENABLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_start,
  input  logic bit6,
  output logic row_msb
);

  generate
    if (ENABLE) begin : g_ext
      logic prev6_q;
      logic tog_q;
      logic tog_d;
      logic fall6;

      assign fall6 = prev6_q && !bit6;
      assign tog_d = tog_q ^ fall6;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev6_q <= 1'b0;
          tog_q   <= 1'b0;
        end else if (ref_start) begin
          prev6_q <= bit6;
          tog_q   <= tog_d;
        end
      end

      assign row_msb = tog_q;
    end else begin : g_noext
      logic unused_ext;
      assign unused_ext = clk ^ rst_n ^ ref_start ^ bit6;
      assign row_msb    = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter bit SPLIT_64K = 1'b0,
  parameter int MA_W      = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              col_sel,
  input  logic              in_ref,
  input  logic              ref_msb,
  output logic [MA_W-1:0]   ma
);

  localparam int HALF_W = half_width(SPLIT_64K);
  localparam int REF_W  = 7;

  logic [MA_W-1:0] row_part;
  logic [MA_W-1:0] col_part;
  logic [MA_W-1:0] ref_part;

  always_comb begin
    row_part              = '0;
    row_part[HALF_W-1:0]  = addr[HALF_W +: HALF_W];
    col_part              = '0;
    col_part[HALF_W-1:0]  = addr[HALF_W-1:0];
  end

  generate
    if (MA_W > REF_W) begin : g_ref_wide
      always_comb begin
        ref_part             = '0;
        ref_part[REF_W-1:0]  = addr[REF_W-1:0];
        ref_part[REF_W]      = ref_msb;
      end
    end else begin : g_ref_narrow
      logic unused_msb;
      assign unused_msb = ref_msb;
      always_comb begin
        ref_part = addr[REF_W-1:0];
      end
    end

    if (ADDR_W > 2*HALF_W) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^addr[ADDR_W-1:2*HALF_W];
    end
  endgenerate

  always_comb begin
    if (in_ref) begin
      ma = ref_part;
    end else if (col_sel) begin
      ma = col_part;
    end else begin
      ma = row_part;
    end
  end

endmodule

// File: rtl/dram_seq_top.sv
module dram_seq_top #(
  parameter int  ADDR_W      = 16,
  parameter bit  SPLIT_64K   = 1'b0,
  parameter bit  REFRESH_EXT = 1'b1,
  localparam int MA_W        = (SPLIT_64K || REFRESH_EXT) ? 8 : 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mreq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              rfsh_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              mux_sel,
  output logic [MA_W-1:0]   ma
);

  logic rst_sync_n;
  logic in_ref;
  logic ref_start;
  logic ref_msb;
  logic col_sel;

  dram_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dram_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .mreq_n    (mreq_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .rfsh_n    (rfsh_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .col_sel   (col_sel),
    .in_ref    (in_ref),
    .ref_start (ref_start)
  );

  dram_refresh_ext #(.ENABLE(REFRESH_EXT)) u_ext (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ref_start (ref_start),
    .bit6      (addr[6]),
    .row_msb   (ref_msb)
  );

  dram_addr_mux #(
    .ADDR_W    (ADDR_W),
    .SPLIT_64K (SPLIT_64K),
    .MA_W      (MA_W)
  ) u_mux (
    .addr    (addr),
    .col_sel (col_sel),
    .in_ref  (in_ref),
    .ref_msb (ref_msb),
    .ma      (ma)
  );

  assign mux_sel = col_sel;

endmodule

// File: rtl/dram_seq_chk.sv
module dram_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic mreq_n,
  input logic rd_n,
  input logic wr_n,
  input logic rfsh_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic mux_sel
);

  // Set one edge after reset release so that $past never reaches into reset.
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
    end
  end

  a_r2_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);

  a_r2_column_addr_first: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $fell(cas_n)) |-> ($past(mux_sel) && mux_sel));

  a_r3_early_write: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $fell(cas_n) && !we_n) |-> $past(!we_n));

  a_r4_no_start_without_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(ras_n && (mreq_n || (rfsh_n && rd_n && wr_n)))) |-> ras_n);

  a_r5_refresh_row_only: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(ras_n && !mreq_n && !rfsh_n)) |-> (!ras_n && cas_n && we_n && !mux_sel));

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(mreq_n)) |-> (ras_n && cas_n && we_n && !mux_sel));

endmodule

bind dram_seq_top dram_seq_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .mreq_n  (mreq_n),
  .rd_n    (rd_n),
  .wr_n    (wr_n),
  .rfsh_n  (rfsh_n),
  .ras_n   (ras_n),
  .cas_n   (cas_n),
  .we_n    (we_n),
  .mux_sel (mux_sel)
);

// File: tb/dram_seq_top_tb.sv
`timescale 1ns/1ps
module dram_seq_top_tb;

  typedef struct {
    string      req;
    logic       ras;
    logic       cas;
    logic       we;
    logic       mux;
    logic [7:0] ma;
    bit         chk_ma;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic [15:0] addr;
  logic        mreq_n, rd_n, wr_n, rfsh_n;
  logic        ras_n, cas_n, we_n, mux_sel;
  logic [7:0]  ma;

  int   checks = 0;
  int   fails  = 0;
  exp_t q[$];

  // Reference refresh-row model
  logic       m_prev6 = 1'b0;
  logic       m_ext   = 1'b0;
  bit [255:0] rows_seen = '0;

  dram_seq_top u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mreq_n(mreq_n), .rd_n(rd_n),
    .wr_n(wr_n), .rfsh_n(rfsh_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .mux_sel(mux_sel), .ma(ma)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic exp_t mk(input string req, input logic ras, input logic cas,
                              input logic we, input logic mux, input logic [7:0] m,
                              input bit chk);
    exp_t e;
    e.req = req; e.ras = ras; e.cas = cas; e.we = we; e.mux = mux;
    e.ma = m; e.chk_ma = chk;
    return e;
  endfunction

  task automatic drive(input logic m, input logic r, input logic w, input logic f,
                       input logic [15:0] a, input exp_t e);
    @(negedge clk);
    mreq_n = m; rd_n = r; wr_n = w; rfsh_n = f; addr = a;
    q.push_back(e);
  endtask

  // Monitor: compares one queued item per cycle, after the edge has settled.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #3;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (ras_n !== e.ras || cas_n !== e.cas || we_n !== e.we || mux_sel !== e.mux ||
            (e.chk_ma && ma !== e.ma)) begin
          fails++;
          $display("FAIL %s: ras/cas/we/mux/ma got %b%b%b%b %h exp %b%b%b%b %h",
                   e.req, ras_n, cas_n, we_n, mux_sel, ma,
                   e.ras, e.cas, e.we, e.mux, e.ma);
        end
      end
    end
  end

  task automatic release_bus(input logic [15:0] a);
    drive(1'b1, 1'b1, 1'b1, 1'b1, a, mk("R7", 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0));
  endtask

  // R2 (read) / R3 (write): row, swap, then column strobe held for 'hold' cycles
  task automatic do_access(input bit is_wr, input logic [15:0] a, input int hold);
    logic [7:0] row, col;
    logic r, w, wexp;
    string tag;
    row  = {1'b0, a[13:7]};
    col  = {1'b0, a[6:0]};
    r    = is_wr;
    w    = !is_wr;
    wexp = !is_wr;
    tag  = is_wr ? "R3" : "R2";
    drive(1'b0, r, w, 1'b1, a, mk(tag, 1'b0, 1'b1, 1'b1, 1'b0, row, 1'b1));
    drive(1'b0, r, w, 1'b1, a, mk(tag, 1'b0, 1'b1, wexp, 1'b1, col, 1'b1));
    for (int k = 0; k < hold; k++)
      drive(1'b0, r, w, 1'b1, a, mk(tag, 1'b0, 1'b0, wexp, 1'b1, col, 1'b1));
    release_bus(a);
  endtask

  // R5 / R6: row-only refresh with predicted eighth row bit
  task automatic do_refresh(input logic [15:0] a);
    logic [7:0] row;
    if (m_prev6 && !a[6]) m_ext = ~m_ext;
    m_prev6 = a[6];
    row = {m_ext, a[6:0]};
    rows_seen[row] = 1'b1;
    drive(1'b0, 1'b1, 1'b1, 1'b0, a, mk("R5_R6", 1'b0, 1'b1, 1'b1, 1'b0, row, 1'b1));
    drive(1'b0, 1'b1, 1'b1, 1'b0, a, mk("R5_R6", 1'b0, 1'b1, 1'b1, 1'b0, row, 1'b1));
    release_bus(a);
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mreq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; rfsh_n = 1'b1; addr = '0;
    repeat (3) @(posedge clk);
    #3;
    checks++;   // R1 during reset
    if (ras_n !== 1'b1 || cas_n !== 1'b1 || we_n !== 1'b1 || mux_sel !== 1'b0) begin
      fails++;
      $display("FAIL R1: got %b%b%b%b exp 1110", ras_n, cas_n, we_n, mux_sel);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #3;
    checks++;   // R1 after release
    if (ras_n !== 1'b1 || cas_n !== 1'b1 || we_n !== 1'b1 || mux_sel !== 1'b0) begin
      fails++;
      $display("FAIL R1: got %b%b%b%b exp 1110", ras_n, cas_n, we_n, mux_sel);
    end

    do_access(1'b0, 16'h2A5B, 2);
    do_access(1'b1, 16'h3FC1, 1);
    do_access(1'b0, 16'hC0FF, 1);
    do_access(1'b1, 16'h1234, 3);

    // R4: request without any command
    for (int k = 0; k < 3; k++)
      drive(1'b0, 1'b1, 1'b1, 1'b1, 16'h5555,
            mk("R4", 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0));
    release_bus(16'h5555);

    // R7: access cut short after the row strobe, and after the swap
    drive(1'b0, 1'b0, 1'b1, 1'b1, 16'h0F80, mk("R2", 1'b0, 1'b1, 1'b1, 1'b0, 8'h1F, 1'b1));
    release_bus(16'h0F80);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 16'h0081, mk("R3", 1'b0, 1'b1, 1'b1, 1'b0, 8'h01, 1'b1));
    drive(1'b0, 1'b1, 1'b0, 1'b1, 16'h0081, mk("R3", 1'b0, 1'b1, 1'b0, 1'b1, 8'h01, 1'b1));
    release_bus(16'h0081);

    // R5/R6: counter-driven refresh with junk in the upper bits
    for (int i = 0; i < 300; i++) begin
      logic [15:0] a;
      a = 16'((i * 16'h04D3) << 7) | 16'(i % 128);
      do_refresh(a);
    end

    do_access(1'b0, 16'h3FFF, 1);

    wait (q.size() == 0);
    repeat (2) @(posedge clk);
    #3;
    checks++;   // R6: all 256 refresh rows reached
    if (rows_seen !== {256{1'b1}}) begin
      fails++;
      $display("FAIL R6: got %0d rows exp 256", $countones(rows_seen));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule